// File: doc/BRIEF.md
# Per-Pin Stimulus Source for a Functional IC Tester

This block supplies the input stimulus for a small functional tester. A single reference clock (4 MHz in the intended use) feeds a cascade of six counter stages. Each stage produces a 50% duty square wave that is slower than the one before it. A divide-by-4 stage gives 1 MHz. Four divide-by-10 stages give 100 kHz, 10 kHz, 1 kHz and 100 Hz. A divide-by-100 stage gives 1 Hz. Every stage runs on the reference clock and advances only on a one-cycle enable tick from the stage before it. No derived clocks exist.

Eight stimulus pins each pick one of eight sources through a 3-bit code. Six codes select the six divided rates. The other two select a constant high or a constant low level. Constant levels suit targets made only of gates. Periodic rates suit targets that hold state. All eight codes come from one packed 24-bit word, which is captured only when the load strobe is high. A test setup is therefore switched in a single cycle.

Top module: `pin_stim_gen`

## Requirements
- R1: While reset is asserted, and straight after it is released, every rate output is low and every pin is low. Reset sets every pin's code to 7 (constant low).
- R2: The first rate output `rate_o[0]` has a period of PRE_DIV reference cycles. It is high for exactly half of that period.
- R3: Each rate output `rate_o[i]` for i = 1..4 has a period of DEC_DIV times the period of `rate_o[i-1]`, with a 50% duty cycle.
- R4: `rate_o[5]` has a period of LAST_DIV times the period of `rate_o[4]`, with a 50% duty cycle.
- R5: Pin n takes its code from `sel_i[3n+2:3n]`. Codes 0 to 5 drive the pin with `rate_o[code]`, where code 0 is the fastest rate and code 5 the slowest.
- R6: Code 6 drives the pin to a constant 1.
- R7: Code 7 drives the pin to a constant 0.
- R8: `sel_i` is captured only in a cycle where `load_i` is 1, and takes effect at the pins from the next cycle. Changes on `sel_i` while `load_i` is 0 do not affect the pins.
- R9: Each pin's source depends only on its own 3-bit field, so any mix of codes across the eight pins is routed correctly.
- R10: The divider cascade runs freely. Loading a new select word does not disturb the period or phase of any rate output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that captures the select word |
| sel_i | input | 24 | Packed select word, 3 bits per pin |
| pin_o | output | 8 | Stimulus pins |
| rate_o | output | 6 | Divided square waves, fastest rate in bit 0 |

## Verification
The bench measures the high time and the low time of every rate output. An off-by-one terminal count, a wrong half-period toggle point, or a stage enabled from the wrong tick would each change one of those numbers. Every pin is rotated through all eight codes, and random mixed words are added on top. This exposes a field sliced from the wrong bits, or constant codes that are swapped or fall into the rate range. The bench also holds `sel_i` at a new value without the strobe, which catches a register that follows its input. It measures a rate while select words are loaded repeatedly, which catches a load path that resets the counters.

// File: rtl/stim_pkg.sv
package stim_pkg;
  localparam int N_RATE = 6;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_R0 = 3'd0,
    SRC_R1 = 3'd1,
    SRC_R2 = 3'd2,
    SRC_R3 = 3'd3,
    SRC_R4 = 3'd4,
    SRC_R5 = 3'd5,
    SRC_HI = 3'd6,
    SRC_LO = 3'd7
  } src_e;
endpackage

// File: rtl/stim_rate_stage.sv
module stim_rate_stage #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o,
  output logic wave_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = en_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_o <= 1'b0;
    end else if (en_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      if (at_last || cnt_q == HALF) wave_o <= ~wave_o;
    end
  end

  // R2: counter never leaves its range
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R10: no enable, no movement
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(wave_o)));
  // R3: a wrap ends the high half
  a_r3_wrap_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> $fell(wave_o));
endmodule

// File: rtl/stim_pin_mux.sv
module stim_pin_mux
  import stim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  code_i,
  input  logic [N_RATE-1:0] rate_i,
  output logic              pin_o
);
  always_comb begin
    unique case (src_e'(code_i))
      SRC_HI:  pin_o = 1'b1;
      SRC_LO:  pin_o = 1'b0;
      default: pin_o = rate_i[code_i];
    endcase
  end

  // R6/R7: a held constant code gives a held pin
  a_r6_const_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i >= SEL_W'(N_RATE)) && $stable(code_i) |-> $stable(pin_o));
endmodule

// File: rtl/pin_stim_gen.sv
module pin_stim_gen
  import stim_pkg::*;
#(
  parameter int PRE_DIV  = 4,
  parameter int DEC_DIV  = 10,
  parameter int LAST_DIV = 100,
  parameter int N_PINS   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [N_PINS*SEL_W-1:0]   sel_i,
  output logic [N_PINS-1:0]         pin_o,
  output logic [N_RATE-1:0]         rate_o
);
  localparam int CFG_W = N_PINS * SEL_W;

  function automatic int stage_div(int idx);
    if (idx == 0)          return PRE_DIV;
    if (idx == N_RATE - 1) return LAST_DIV;
    return DEC_DIV;
  endfunction

  logic [N_RATE:0]  tick;
  logic [CFG_W-1:0] cfg_q;

  assign tick[0] = 1'b1;

  for (genvar g = 0; g < N_RATE; g++) begin : g_stage
    stim_rate_stage #(.DIV(stage_div(g))) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (tick[g]),
      .tick_o (tick[g+1]),
      .wave_o (rate_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '1;
    else if (load_i) cfg_q <= sel_i;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    stim_pin_mux u_mux (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (cfg_q[p*SEL_W +: SEL_W]),
      .rate_i (rate_o),
      .pin_o  (pin_o[p])
    );
  end

  // R8: the word moves only on a strobe, and then to the sampled input
  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));
  a_r8_cfg_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cfg_q == $past(sel_i));
  // R4: the final stage's wrap drops the slowest rate
  a_r4_last_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick[N_RATE] |=> $fell(rate_o[N_RATE-1]));
  // R10: a slower rate only moves on the fastest rate's edge
  a_r10_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(rate_o[1]) |-> $changed(rate_o[0]));
endmodule

// File: tb/sim_pin_stim_gen.sv
`timescale 1ns/1ps
module sim_pin_stim_gen;
  localparam int PRE  = 4;
  localparam int DEC  = 4;
  localparam int LAST = 6;
  localparam int NP   = 8;
  localparam int NR   = 6;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            load_i = 1'b0;
  logic [NP*3-1:0] sel_i = '0;
  logic [NP-1:0]   pin_o;
  logic [NR-1:0]   rate_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  pin_stim_gen #(.PRE_DIV(PRE), .DEC_DIV(DEC), .LAST_DIV(LAST), .N_PINS(NP)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .sel_i(sel_i),
    .pin_o(pin_o), .rate_o(rate_o)
  );

  function automatic int exp_period(int idx);
    int p = PRE;
    for (int i = 1; i <= idx; i++) p = p * ((i == NR - 1) ? LAST : DEC);
    return p;
  endfunction

  function automatic logic [NP-1:0] exp_pins(logic [NP*3-1:0] w, logic [NR-1:0] r);
    logic [NP-1:0] v;
    for (int n = 0; n < NP; n++) begin
      logic [2:0] c = w[n*3 +: 3];
      v[n] = (c < 3'd6) ? r[c] : (c == 3'd6);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [NP*3-1:0] w);
    @(negedge clk_i);
    sel_i  = w;
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic check_routing(input logic [NP*3-1:0] w, input string req);
    for (int k = 0; k < 6; k++) begin
      logic [NP-1:0] e = exp_pins(w, rate_o);
      chk(pin_o == e, req, int'(pin_o), int'(e));
      repeat (3) @(negedge clk_i);
    end
  endtask

  task automatic measure(input int idx, input string req);
    int hi = 0;
    int lo = 0;
    int p  = exp_period(idx);
    while (rate_o[idx]) @(negedge clk_i);
    while (!rate_o[idx]) @(negedge clk_i);
    while (rate_o[idx]) begin @(negedge clk_i); hi++; end
    while (!rate_o[idx]) begin @(negedge clk_i); lo++; end
    chk(hi == p / 2, req, hi, p / 2);
    chk(lo == p / 2, req, lo, p / 2);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NP*3-1:0] w;
    int seed_dummy;
    seed_dummy = $urandom(32'd7);

    repeat (3) @(negedge clk_i);
    chk(pin_o == '0, "R1 pins in reset", int'(pin_o), 0);
    chk(rate_o == '0, "R1 rates in reset", int'(rate_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pin_o == '0, "R1 pins after reset", int'(pin_o), 0);
    chk(rate_o == '0, "R1 rates after reset", int'(rate_o), 0);

    measure(0, "R2 rate0");
    measure(1, "R3 rate1");
    measure(2, "R3 rate2");
    measure(3, "R3 rate3");
    measure(4, "R3 rate4");
    measure(5, "R4 rate5");

    load_word({NP{3'd6}});
    chk(pin_o == '1, "R6 all high", int'(pin_o), 8'hFF);
    load_word({NP{3'd7}});
    chk(pin_o == '0, "R7 all low", int'(pin_o), 0);

    for (int k = 0; k < 8; k++) begin
      for (int n = 0; n < NP; n++) w[n*3 +: 3] = 3'((n + k) % 8);
      load_word(w);
      check_routing(w, "R5/R6/R7 rotation");
    end

    load_word({NP{3'd6}});
    @(negedge clk_i);
    sel_i = {NP{3'd7}};
    repeat (20) @(negedge clk_i);
    chk(pin_o == '1, "R8 no strobe", int'(pin_o), 8'hFF);
    sel_i = {NP{3'd0}};
    repeat (5) @(negedge clk_i);
    chk(pin_o == '1, "R8 no strobe again", int'(pin_o), 8'hFF);
    load_word({NP{3'd7}});
    chk(pin_o == '0, "R8 strobe takes", int'(pin_o), 0);

    for (int t = 0; t < 24; t++) begin
      w = 24'($urandom());
      load_word(w);
      check_routing(w, "R9 random mix");
    end

    fork
      measure(2, "R10 rate2 under loads");
      for (int t = 0; t < 40; t++) load_word(24'($urandom()));
    join
    measure(0, "R10 rate0 after loads");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule